// File: doc/BRIEF.md
# Serial Link Master Status and Interrupt Unit

This block keeps the status word and the interrupt mask of a serial link master controller. Its inputs are event strobes and live levels from the parts of the controller around it: the link receiver (word arrival with its parity flag), the receive and transmit queues (full, not-empty, not-full), the bus master (error response) and the sequence engine (element written back, sequence start, sequence done, abort acknowledge). Software reads one 32-bit status word, clears sticky flags by writing ones, programs an 8-bit interrupt mask and requests a sequence abort through a control write. The block drives one interrupt line, a push strobe for accepted receive words, and an abort strobe toward the sequence engine.

The status bits depend on each other. A bus error forces any pending abort back to idle and clears the aborted flag. A word counts as received only if it had good parity and found room in the queue. The 10-bit sequence index wraps after 1024 write-backs, so software needs the completion flag to tell an empty run from a full one.

The abort handshake is a three-state machine. In ABT_IDLE no abort is pending. A control write with bit 1 set moves it to ABT_ISSUE, which raises the abort strobe for one cycle. The machine then always moves to ABT_WAIT. From ABT_WAIT an acknowledge returns it to ABT_IDLE and sets the aborted flag. A bus error strobe sends any state to ABT_IDLE, and this transition takes priority over every other one.

Top module: `slink_stat_irq`

## Requirements
- R1: After reset the status word reads 0x00000008 (transmit-not-full input high, receive-not-empty input low), the mask reads 0x00, and irq, seq_abort and ctrl_abort are low.
- R2: Status bit 4 follows rxq_not_empty and bit 3 follows txq_not_full in the same cycle. Writing the status register does not change them. Bits 31:26 and 15:8 always read 0.
- R3: A word arrival (rx_word_vld) with rx_word_perr set sets bit 7 and is not pushed. A good-parity arrival while rxq_full is high sets bit 5 and is not pushed. A good-parity arrival with room raises rxq_push in that cycle and sets bit 0. Bit 0 is never set by a rejected word, and parity takes precedence over overflow.
- R4: Bits 7, 6, 5, 2, 1 and 0 are sticky. Writing status (reg_wr_sel=0) with a 1 in a bit position clears that bit, and writing 0 leaves it unchanged. If a set event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Bits 25:16 hold the sequence index. seq_start resets it to 0, and each seq_elem_wr adds 1 modulo 1024, so the index reads 0 after 1024 elements. seq_done sets bit 2.
- R6: A control write (reg_wr_sel=2) with data bit 1 set in ABT_IDLE raises seq_abort for exactly one cycle, starting the cycle after the write. ctrl_abort then stays high until seq_abort_ack arrives in ABT_WAIT, which sets status bit 1 and returns the machine to idle.
- R7: A bus_err strobe sets bit 6, raises seq_abort in the same cycle, forces ctrl_abort low and clears status bit 1 on the next cycle. It overrides an acknowledge that arrives in the same cycle.
- R8: A write with reg_wr_sel=1 loads mask_rdata from reg_wr_data. Mask bit n enables status bit n (7..0).
- R9: irq goes high for one cycle, one cycle after an enabled status bit goes from 0 to 1. For bus errors, every bus_err strobe counts as an event, even when bit 6 is already set. Events whose mask bit is clear never raise irq.
- R10: seq_abort_ack outside ABT_WAIT is ignored and leaves status bit 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write target: 0 status, 1 mask, 2 control |
| reg_wr_data | input | 8 | Write data (low byte of the bus word) |
| stat_rdata | output | 32 | Status word |
| mask_rdata | output | 8 | Interrupt mask |
| ctrl_abort | output | 1 | Control abort bit readback (abort pending) |
| rx_word_vld | input | 1 | A word arrived from the link |
| rx_word_perr | input | 1 | The arriving word failed its parity check |
| rxq_full | input | 1 | Receive queue is full |
| rxq_push | output | 1 | Arriving word is accepted into the receive queue |
| rxq_not_empty | input | 1 | Receive queue holds at least one word |
| txq_not_full | input | 1 | Transmit queue has a free slot |
| bus_err | input | 1 | Bus master received an error response |
| seq_start | input | 1 | Sequence engine starts a new run |
| seq_elem_wr | input | 1 | Sequence engine wrote back one element |
| seq_done | input | 1 | Sequence engine finished its run |
| seq_abort_ack | input | 1 | Sequence engine acknowledges an abort |
| seq_abort | output | 1 | Abort strobe toward the sequence engine |
| irq | output | 1 | Interrupt pulse |

## Verification
The embedded assertions check on every cycle that a set event always wins over a same-cycle clear, that a clear without a set drops a sticky flag, that the index wraps from all-ones to zero, that a bus error leaves both the aborted flag and the control abort low, that the abort strobe lasts one cycle, and that an enabled bus error always produces an interrupt. Some behaviours can only be shown by the bench scenarios. These are the full table of word arrival outcomes, the count of 1024 write-backs ending at index zero with the done flag set, an acknowledge arriving in the same cycle as a bus error, and interrupt pulses that repeat for repeated errors but never appear for masked events.

// File: rtl/slsi_pkg.sv
package slsi_pkg;

    localparam int STAT_W   = 32;
    localparam int EV_W     = 8;
    localparam int STICKY_N = 6;
    localparam int IDX_LSB  = 16;

    // status bit positions
    localparam int B_PERR = 7;
    localparam int B_BERR = 6;
    localparam int B_ROV  = 5;
    localparam int B_RNE  = 4;
    localparam int B_TNF  = 3;
    localparam int B_SC   = 2;
    localparam int B_SA   = 1;
    localparam int B_SRX  = 0;

    // packed order of the six sticky flags
    localparam int S_PERR = 5;
    localparam int S_BERR = 4;
    localparam int S_ROV  = 3;
    localparam int S_SC   = 2;
    localparam int S_SA   = 1;
    localparam int S_SRX  = 0;

    typedef enum logic [1:0] {
        ABT_IDLE  = 2'd0,
        ABT_ISSUE = 2'd1,
        ABT_WAIT  = 2'd2
    } abt_state_t;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_t;

endpackage

// File: rtl/slsi_seq_index.sv
module slsi_seq_index #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && idx == {IDX_W{1'b1}}) |=> idx == '0); // R5

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(idx)); // R5

endmodule

// File: rtl/slsi_sticky.sv
module slsi_sticky #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else begin
                q[b] <= set[b] | (q[b] & ~clr[b]);
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[b] |=> q[b]); // R4

        AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[b] && !set[b]) |=> !q[b]); // R4
    end

endmodule

// File: rtl/slsi_abort_fsm.sv
module slsi_abort_fsm
    import slsi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort_wr,
    input  logic abort_ack,
    input  logic bus_err,
    output logic seq_abort,
    output logic ctrl_abort,
    output logic ack_accept
);

    abt_state_t state_q;
    abt_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ABT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (bus_err) begin
            state_d = ABT_IDLE;
        end else begin
            unique case (state_q)
                ABT_IDLE:  if (abort_wr)  state_d = ABT_ISSUE;
                ABT_ISSUE: state_d = ABT_WAIT;
                ABT_WAIT:  if (abort_ack) state_d = ABT_IDLE;
                default:   state_d = ABT_IDLE;
            endcase
        end
    end

    always_comb begin
        seq_abort  = (state_q == ABT_ISSUE) | bus_err;
        ctrl_abort = (state_q != ABT_IDLE);
        ack_accept = (state_q == ABT_WAIT) & abort_ack & ~bus_err;
    end

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_abort && !bus_err) |=> (seq_abort == bus_err)); // R6

    AST_BERR_DROPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !ctrl_abort); // R7

    AST_ACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_accept |-> ctrl_abort); // R10

endmodule

// File: rtl/slsi_irq_gen.sv
module slsi_irq_gen
    import slsi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STICKY_N-1:0] set,
    input  logic [STICKY_N-1:0] q,
    input  logic                rne,
    input  logic                tnf,
    input  logic [EV_W-1:0]     mask,
    output logic                irq
);

    logic            rne_q;
    logic            tnf_q;
    logic [EV_W-1:0] ev;

    always_comb begin
        ev         = '0;
        ev[B_PERR] = set[S_PERR] & ~q[S_PERR];
        ev[B_BERR] = set[S_BERR];
        ev[B_ROV]  = set[S_ROV] & ~q[S_ROV];
        ev[B_RNE]  = rne & ~rne_q;
        ev[B_TNF]  = tnf & ~tnf_q;
        ev[B_SC]   = set[S_SC] & ~q[S_SC];
        ev[B_SA]   = set[S_SA] & ~q[S_SA];
        ev[B_SRX]  = set[S_SRX] & ~q[S_SRX];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rne_q <= 1'b0;
            tnf_q <= 1'b1;
            irq   <= 1'b0;
        end else begin
            rne_q <= rne;
            tnf_q <= tnf;
            irq   <= |(ev & mask);
        end
    end

    AST_IRQ_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        (set[S_BERR] && mask[B_BERR]) |=> irq); // R9

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|mask)); // R9

endmodule

// File: rtl/slink_stat_irq.sv
module slink_stat_irq
    import slsi_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [EV_W-1:0]   reg_wr_data,
    output logic [STAT_W-1:0] stat_rdata,
    output logic [EV_W-1:0]   mask_rdata,
    output logic              ctrl_abort,
    input  logic              rx_word_vld,
    input  logic              rx_word_perr,
    input  logic              rxq_full,
    output logic              rxq_push,
    input  logic              rxq_not_empty,
    input  logic              txq_not_full,
    input  logic              bus_err,
    input  logic              seq_start,
    input  logic              seq_elem_wr,
    input  logic              seq_done,
    input  logic              seq_abort_ack,
    output logic              seq_abort,
    output logic              irq
);

    localparam logic [EV_W-1:0] STICKY_POS =
        (EV_W'(1) << B_PERR) | (EV_W'(1) << B_BERR) | (EV_W'(1) << B_ROV) |
        (EV_W'(1) << B_SC)   | (EV_W'(1) << B_SA)   | (EV_W'(1) << B_SRX);

    logic                wr_stat;
    logic                wr_mask;
    logic                abort_wr;
    logic                ack_accept;
    logic [EV_W-1:0]     w1c;
    logic [STICKY_N-1:0] st_set;
    logic [STICKY_N-1:0] st_clr;
    logic [STICKY_N-1:0] st_q;
    logic [IDX_W-1:0]    idx;

    // register write decode
    always_comb begin
        wr_stat  = reg_wr_en && (reg_wr_sel == SEL_STAT);
        wr_mask  = reg_wr_en && (reg_wr_sel == SEL_MASK);
        abort_wr = reg_wr_en && (reg_wr_sel == SEL_CTRL) && reg_wr_data[B_SA];
        w1c      = wr_stat ? (reg_wr_data & STICKY_POS) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_rdata <= '0;
        end else if (wr_mask) begin
            mask_rdata <= reg_wr_data;
        end
    end

    // receive word qualification
    always_comb begin
        rxq_push = rx_word_vld & ~rx_word_perr & ~rxq_full;
    end

    // sticky flag set and clear vectors
    always_comb begin
        st_set         = '0;
        st_set[S_PERR] = rx_word_vld & rx_word_perr;
        st_set[S_BERR] = bus_err;
        st_set[S_ROV]  = rx_word_vld & ~rx_word_perr & rxq_full;
        st_set[S_SC]   = seq_done;
        st_set[S_SA]   = ack_accept;
        st_set[S_SRX]  = rxq_push;

        st_clr         = '0;
        st_clr[S_PERR] = w1c[B_PERR];
        st_clr[S_BERR] = w1c[B_BERR];
        st_clr[S_ROV]  = w1c[B_ROV];
        st_clr[S_SC]   = w1c[B_SC];
        st_clr[S_SA]   = w1c[B_SA] | bus_err;
        st_clr[S_SRX]  = w1c[B_SRX];
    end

    slsi_sticky #(.N(STICKY_N)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (st_set),
        .clr   (st_clr),
        .q     (st_q)
    );

    slsi_seq_index #(.IDX_W(IDX_W)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (seq_start),
        .step  (seq_elem_wr),
        .idx   (idx)
    );

    slsi_abort_fsm u_abort (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_wr   (abort_wr),
        .abort_ack  (seq_abort_ack),
        .bus_err    (bus_err),
        .seq_abort  (seq_abort),
        .ctrl_abort (ctrl_abort),
        .ack_accept (ack_accept)
    );

    slsi_irq_gen u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (st_set),
        .q     (st_q),
        .rne   (rxq_not_empty),
        .tnf   (txq_not_full),
        .mask  (mask_rdata),
        .irq   (irq)
    );

    // status word assembly
    always_comb begin
        stat_rdata                     = '0;
        stat_rdata[IDX_LSB +: IDX_W]   = idx;
        stat_rdata[B_PERR]             = st_q[S_PERR];
        stat_rdata[B_BERR]             = st_q[S_BERR];
        stat_rdata[B_ROV]              = st_q[S_ROV];
        stat_rdata[B_RNE]              = rxq_not_empty;
        stat_rdata[B_TNF]              = txq_not_full;
        stat_rdata[B_SC]               = st_q[S_SC];
        stat_rdata[B_SA]               = st_q[S_SA];
        stat_rdata[B_SRX]              = st_q[S_SRX];
    end

    AST_SRX_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_vld && !rx_word_perr && !rxq_full) |=> stat_rdata[B_SRX]); // R3

    AST_BAD_WORD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_vld && (rx_word_perr || rxq_full)) |-> !rxq_push); // R3

    AST_BERR_CLEARS_SA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> (!stat_rdata[B_SA] && stat_rdata[B_BERR])); // R7

endmodule

// File: tb/sim_slink_stat_irq.sv
`timescale 1ns/1ps
module sim_slink_stat_irq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_sel;
    logic [7:0]  reg_wr_data;
    logic [31:0] stat_rdata;
    logic [7:0]  mask_rdata;
    logic        ctrl_abort;
    logic        rx_word_vld, rx_word_perr, rxq_full, rxq_push;
    logic        rxq_not_empty, txq_not_full;
    logic        bus_err, seq_start, seq_elem_wr, seq_done, seq_abort_ack;
    logic        seq_abort, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    slink_stat_irq u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .stat_rdata(stat_rdata), .mask_rdata(mask_rdata), .ctrl_abort(ctrl_abort),
        .rx_word_vld(rx_word_vld), .rx_word_perr(rx_word_perr), .rxq_full(rxq_full),
        .rxq_push(rxq_push), .rxq_not_empty(rxq_not_empty), .txq_not_full(txq_not_full),
        .bus_err(bus_err), .seq_start(seq_start), .seq_elem_wr(seq_elem_wr),
        .seq_done(seq_done), .seq_abort_ack(seq_abort_ack),
        .seq_abort(seq_abort), .irq(irq)
    );

    // {vld, perr, full, exp_push, exp_bit7, exp_bit5, exp_bit0}
    localparam logic [6:0] RX_TAB [0:5] = '{
        7'b100_1001,
        7'b110_0100,
        7'b101_0010,
        7'b111_0100,
        7'b011_0000,
        7'b000_0000
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] data);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = data;
        tick();
        reg_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        reg_wr_en = 1'b0; reg_wr_sel = 2'd0; reg_wr_data = 8'h00;
        rx_word_vld = 1'b0; rx_word_perr = 1'b0; rxq_full = 1'b0;
        rxq_not_empty = 1'b0; txq_not_full = 1'b1;
        bus_err = 1'b0; seq_start = 1'b0; seq_elem_wr = 1'b0;
        seq_done = 1'b0; seq_abort_ack = 1'b0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;

        // R1 reset state
        check("R1 status", stat_rdata, 32'h0000_0008);
        check("R1 mask", {24'd0, mask_rdata}, 32'd0);
        check("R1 irq/abort", {29'd0, irq, seq_abort, ctrl_abort}, 32'd0);

        // R2 live levels, write has no effect
        rxq_not_empty = 1'b1; txq_not_full = 1'b0;
        #1 check("R2 live levels", stat_rdata, 32'h0000_0010);
        reg_write(2'd0, 8'hFF);
        check("R2 after write", stat_rdata, 32'h0000_0010);
        rxq_not_empty = 1'b0; txq_not_full = 1'b1;
        tick();

        // R3 word arrival table
        for (int i = 0; i < 6; i++) begin
            reg_write(2'd0, 8'hFF);
            rx_word_vld  = RX_TAB[i][6];
            rx_word_perr = RX_TAB[i][5];
            rxq_full     = RX_TAB[i][4];
            #1 check("R3 push", {31'd0, rxq_push}, {31'd0, RX_TAB[i][3]});
            tick();
            rx_word_vld = 1'b0; rx_word_perr = 1'b0; rxq_full = 1'b0;
            check("R3 flags", {29'd0, stat_rdata[7], stat_rdata[5], stat_rdata[0]},
                  {29'd0, RX_TAB[i][2:0]});
        end

        // R4 write-one-to-clear and set-wins
        reg_write(2'd0, 8'hFF);
        rx_word_vld = 1'b1; tick(); rx_word_vld = 1'b0;
        reg_write(2'd0, 8'h00);
        check("R4 write zero keeps", {31'd0, stat_rdata[0]}, 32'd1);
        reg_write(2'd0, 8'h01);
        check("R4 write one clears", {31'd0, stat_rdata[0]}, 32'd0);
        rx_word_vld = 1'b1;
        reg_write(2'd0, 8'h01);
        rx_word_vld = 1'b0;
        check("R4 set wins", {31'd0, stat_rdata[0]}, 32'd1);
        reg_write(2'd0, 8'hFF);

        // R5 sequence index and wrap
        seq_start = 1'b1; tick(); seq_start = 1'b0;
        seq_elem_wr = 1'b1; repeat (3) tick(); seq_elem_wr = 1'b0;
        check("R5 index 3", {22'd0, stat_rdata[25:16]}, 32'd3);
        seq_elem_wr = 1'b1;
        for (int k = 0; k < 1021; k++) begin
            seq_done = (k == 1020);
            tick();
        end
        seq_elem_wr = 1'b0; seq_done = 1'b0;
        check("R5 wrap and done", stat_rdata, 32'h0000_000C);

        // R8 mask
        reg_write(2'd1, 8'hA5);
        check("R8 mask readback", {24'd0, mask_rdata}, 32'h0000_00A5);
        reg_write(2'd1, 8'h00);

        // R10 ack ignored when idle
        seq_abort_ack = 1'b1; tick(); seq_abort_ack = 1'b0;
        check("R10 idle ack", {31'd0, stat_rdata[1]}, 32'd0);

        // R6 abort handshake
        reg_write(2'd2, 8'h02);
        check("R6 strobe", {30'd0, seq_abort, ctrl_abort}, 32'd3);
        tick();
        check("R6 strobe ends", {30'd0, seq_abort, ctrl_abort}, 32'd1);
        seq_abort_ack = 1'b1; tick(); seq_abort_ack = 1'b0;
        check("R6 aborted set", {30'd0, stat_rdata[1], ctrl_abort}, 32'd2);

        // R7 bus error overrides ack, clears aborted flag
        reg_write(2'd2, 8'h02);
        tick();
        bus_err = 1'b1; seq_abort_ack = 1'b1;
        #1 check("R7 abort strobe", {31'd0, seq_abort}, 32'd1);
        tick();
        bus_err = 1'b0; seq_abort_ack = 1'b0;
        check("R7 flags", {29'd0, stat_rdata[6], stat_rdata[1], ctrl_abort}, 32'd4);

        // R9 interrupts
        reg_write(2'd1, 8'h40);
        bus_err = 1'b1; tick(); bus_err = 1'b0;
        check("R9 berr irq", {31'd0, irq}, 32'd1);
        tick();
        check("R9 irq one cycle", {31'd0, irq}, 32'd0);
        bus_err = 1'b1; tick(); bus_err = 1'b0;
        check("R9 repeat berr irq", {31'd0, irq}, 32'd1);
        reg_write(2'd1, 8'h10);
        rxq_not_empty = 1'b1; tick();
        check("R9 rne rise irq", {31'd0, irq}, 32'd1);
        tick();
        check("R9 rne level no irq", {31'd0, irq}, 32'd0);
        reg_write(2'd1, 8'h00);
        bus_err = 1'b1; tick(); bus_err = 1'b0;
        check("R9 masked berr", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule